// File: doc/BRIEF.md
# LPC Memory Window Decoder

This block classifies each memory cycle seen on a host LPC bus against a set of address windows. One window holds the boot firmware and always sits at the very top of the 4 GB space, reaching down by a selectable power of two from 256 KB to 32 MB. The other windows are general-purpose zones. Each zone has its base given by two byte registers for address bits 31:24 and 23:16, and a power-of-two size of its own. For every request the block reports, one clock later, which window was hit and the 28-bit address to be driven on the downstream memory bus.

The firmware window is checked in two ways. A plain LPC memory cycle must match on the full 32-bit address. A firmware-hub cycle carries a 4-bit device ID and a 28-bit address, and it must match on the ID and on the upper address bits that the window size leaves significant. Each path is gated by its own enable, which comes from the boot-protocol detector outside the block. A lock bit can be set once by software. It then freezes the whole mapping until reset, so that the map cannot later be changed to alias protected space.

Top module: `lpc_memwin_dec`

## Requirements
- R1: After reset, every mapping register reads 0, the lock is clear, all zones are disabled, and out_valid, out_bios_hit, out_zone_hit and out_addr are 0.
- R2: An LPC memory request (req_fwh=0) with lpc_bios_en=1 sets out_bios_hit exactly when req_addr >= 2^32 - (256 KB << C). C is the 3-bit firmware size code held in register index 0, bits 2:0.
- R3: A firmware-hub request (req_fwh=1) with fwh_bios_en=1 sets out_bios_hit exactly when req_id equals the DEV_ID parameter (default 0) and req_addr[27:0] >= 2^28 - (256 KB << C). Bits 31:28 are ignored.
- R4: out_bios_hit is never set for an LPC request while lpc_bios_en=0, nor for a firmware-hub request while fwh_bios_en=0.
- R5: Zone z is hit by an LPC memory request exactly when it is enabled and req_addr lies in [B, B+S). The registers for zone z are: index 2+3z holds base bits 31:24, index 3+3z holds base bits 23:16, and index 4+3z holds the enable in bit 7 and the size code K in bits 2:0. S = 64 KB << K, and B is the base with its bits below log2(S) cleared, so a misaligned base falls back to the aligned block. Firmware-hub requests never hit a zone.
- R6: At most one hit output is set. The firmware window takes priority over all zones, and a lower-numbered zone takes priority over a higher one.
- R7: Each request with req_valid=1 produces, at the next clock edge, out_valid=1 and out_addr=req_addr[27:0]. A cycle with req_valid=0 produces out_valid=0, all hits 0 and out_addr=0.
- R8: Writing register index 1 with bit 0 set sets the lock. Writing 0 there does not clear it. Only reset clears it. It reads back in bit 0.
- R9: While the lock is set, writes to registers index 0 and 2..(1+3*NUM_ZONES) are ignored. Both readback and decode stay unchanged.
- R10: cfg_rdata combinationally shows the register selected by cfg_sel. Bits a register does not hold read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | SEL_W | Register index for write and readback |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Readback of the selected register |
| lpc_bios_en | input | 1 | Allows firmware-window hits for LPC memory cycles |
| fwh_bios_en | input | 1 | Allows firmware-window hits for firmware-hub cycles |
| req_valid | input | 1 | Request present this cycle |
| req_fwh | input | 1 | 1 = firmware-hub cycle, 0 = LPC memory cycle |
| req_id | input | ID_W | Device ID of a firmware-hub cycle |
| req_addr | input | 32 | Request address |
| out_valid | output | 1 | Decode result present |
| out_bios_hit | output | 1 | Firmware window hit |
| out_zone_hit | output | NUM_ZONES | One bit per zone hit |
| out_addr | output | FWD_W | Address for the downstream bus |

## Verification
The assertions check on every cycle that out_valid and out_addr follow the previous request. They also check that at most one hit is raised, that a firmware hit only appears for a path whose enable was set, and that zone hits never come from firmware-hub cycles. They further check that the lock never drops and that the mapping registers cannot move while it is set. Only the bench scenarios can show that the window edges land on the right addresses for several size codes, that a misaligned base falls back to its aligned block, and that overlapping windows are resolved in the right order. The same holds for readback masking and for a reset clearing the lock.

// File: rtl/lpc_memwin_pkg.sv
package lpc_memwin_pkg;

   localparam int LMW_ADDR_W = 32;
   localparam int LMW_CODE_W = 3;
   localparam int LMW_BYTE_W = 8;

   typedef struct packed {
      logic [LMW_BYTE_W-1:0] base_hi;
      logic [LMW_BYTE_W-1:0] base_lo;
      logic                  en;
      logic [LMW_CODE_W-1:0] code;
   } zone_cfg_t;

   // Mask keeping address bits at and above lsb.
   function automatic logic [LMW_ADDR_W-1:0] upper_mask(input int unsigned lsb);
      upper_mask = {LMW_ADDR_W{1'b1}} << lsb;
   endfunction

endpackage

// File: rtl/lpc_memwin_regs.sv
module lpc_memwin_regs
   import lpc_memwin_pkg::*;
#(
   parameter int NUM_ZONES = 2,
   parameter int SEL_W     = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [SEL_W-1:0]                 sel,
   input  logic [LMW_BYTE_W-1:0]            wdata,
   output logic [LMW_BYTE_W-1:0]            rd_data,
   output logic [LMW_CODE_W-1:0]            bios_code,
   output zone_cfg_t [NUM_ZONES-1:0]        zone_cfg,
   output logic                             lock
);

   localparam int IDX_BIOS = 0;
   localparam int IDX_LOCK = 1;
   localparam int IDX_ZONE = 2;

   logic                  lock_q;
   logic                  wr_ok;
   logic [LMW_CODE_W-1:0] bios_code_q;

   assign wr_ok = wr_en && !lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
      end else if (wr_en && sel == SEL_W'(IDX_LOCK) && wdata[0]) begin
         lock_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bios_code_q <= '0;
      end else if (wr_ok && sel == SEL_W'(IDX_BIOS)) begin
         bios_code_q <= wdata[LMW_CODE_W-1:0];
      end
   end

   for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
      localparam int IDX_HI = IDX_ZONE + 3*z;
      localparam int IDX_LO = IDX_HI + 1;
      localparam int IDX_SZ = IDX_HI + 2;
      zone_cfg_t cfg_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q <= '0;
         end else if (wr_ok) begin
            if (sel == SEL_W'(IDX_HI)) cfg_q.base_hi <= wdata;
            if (sel == SEL_W'(IDX_LO)) cfg_q.base_lo <= wdata;
            if (sel == SEL_W'(IDX_SZ)) begin
               cfg_q.en   <= wdata[LMW_BYTE_W-1];
               cfg_q.code <= wdata[LMW_CODE_W-1:0];
            end
         end
      end

      assign zone_cfg[z] = cfg_q;
   end

   always_comb begin
      rd_data = '0;
      if (sel == SEL_W'(IDX_BIOS)) rd_data[LMW_CODE_W-1:0] = bios_code_q;
      if (sel == SEL_W'(IDX_LOCK)) rd_data[0] = lock_q;
      for (int z = 0; z < NUM_ZONES; z++) begin
         if (sel == SEL_W'(IDX_ZONE + 3*z))     rd_data = zone_cfg[z].base_hi;
         if (sel == SEL_W'(IDX_ZONE + 3*z + 1)) rd_data = zone_cfg[z].base_lo;
         if (sel == SEL_W'(IDX_ZONE + 3*z + 2)) begin
            rd_data[LMW_BYTE_W-1]   = zone_cfg[z].en;
            rd_data[LMW_CODE_W-1:0] = zone_cfg[z].code;
         end
      end
   end

   assign bios_code = bios_code_q;
   assign lock      = lock_q;

endmodule

// File: rtl/lpc_memwin_bios.sv
module lpc_memwin_bios
   import lpc_memwin_pkg::*;
#(
   parameter int          MIN_LOG2  = 18,
   parameter int          FWD_W     = 28,
   parameter int          ID_W      = 4,
   parameter bit          CHECK_ID  = 1'b1,
   parameter logic [3:0]  DEV_ID    = 4'h0
) (
   input  logic [LMW_ADDR_W-1:0] addr,
   input  logic                  is_fwh,
   input  logic [ID_W-1:0]       id,
   input  logic [LMW_CODE_W-1:0] code,
   input  logic                  lpc_en,
   input  logic                  fwh_en,
   output logic                  hit
);

   logic [LMW_ADDR_W-1:0] win_mask;
   logic                  lpc_top;
   logic                  fwh_top;
   logic                  id_ok;

   assign win_mask = upper_mask(MIN_LOG2 + int'(code));

   // Window ends at the top of the space: all significant bits must be one.
   assign lpc_top = &(addr | ~win_mask);
   assign fwh_top = &(addr[FWD_W-1:0] | ~win_mask[FWD_W-1:0]);

   if (CHECK_ID) begin : g_id_check
      assign id_ok = (id == ID_W'(DEV_ID));
   end else begin : g_id_any
      assign id_ok = 1'b1;
   end

   assign hit = is_fwh ? (fwh_en && id_ok && fwh_top)
                       : (lpc_en && lpc_top);

endmodule

// File: rtl/lpc_memwin_zone.sv
module lpc_memwin_zone
   import lpc_memwin_pkg::*;
#(
   parameter int MIN_LOG2 = 16
) (
   input  logic [LMW_ADDR_W-1:0] addr,
   input  zone_cfg_t             cfg,
   output logic                  hit
);

   localparam int LOW_W = LMW_ADDR_W - 2*LMW_BYTE_W;

   logic [LMW_ADDR_W-1:0] base;
   logic [LMW_ADDR_W-1:0] blk_mask;

   assign base     = {cfg.base_hi, cfg.base_lo, {LOW_W{1'b0}}};
   assign blk_mask = upper_mask(MIN_LOG2 + int'(cfg.code));

   // Base bits under the block size are masked away, never partially compared.
   assign hit = cfg.en && (((addr ^ base) & blk_mask) == '0);

endmodule

// File: rtl/lpc_memwin_dec.sv
module lpc_memwin_dec
   import lpc_memwin_pkg::*;
#(
   parameter int          NUM_ZONES      = 2,
   parameter int          FWD_W          = 28,
   parameter int          ID_W           = 4,
   parameter int          BIOS_MIN_LOG2  = 18,
   parameter int          ZONE_MIN_LOG2  = 16,
   parameter bit          FWH_CHECK_ID   = 1'b1,
   parameter logic [3:0]  DEV_ID         = 4'h0,
   localparam int         NUM_REGS       = 2 + 3*NUM_ZONES,
   localparam int         SEL_W          = $clog2(NUM_REGS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [SEL_W-1:0]      cfg_sel,
   input  logic [7:0]            cfg_wdata,
   output logic [7:0]            cfg_rdata,
   input  logic                  lpc_bios_en,
   input  logic                  fwh_bios_en,
   input  logic                  req_valid,
   input  logic                  req_fwh,
   input  logic [ID_W-1:0]       req_id,
   input  logic [31:0]           req_addr,
   output logic                  out_valid,
   output logic                  out_bios_hit,
   output logic [NUM_ZONES-1:0]  out_zone_hit,
   output logic [FWD_W-1:0]      out_addr
);

   localparam int MAP_W = LMW_CODE_W + NUM_ZONES*$bits(zone_cfg_t);
   localparam int TOP_CODE = (1 << LMW_CODE_W) - 1;

   if (NUM_ZONES < 1) begin : g_bad_zones
      $error("NUM_ZONES must be at least 1");
   end
   if (FWD_W < BIOS_MIN_LOG2 + TOP_CODE + 1 || FWD_W > LMW_ADDR_W) begin : g_bad_fwd
      $error("FWD_W must hold the largest firmware window and fit the address");
   end
   if (ZONE_MIN_LOG2 < 16 || ZONE_MIN_LOG2 + TOP_CODE >= LMW_ADDR_W) begin : g_bad_zone_log2
      $error("ZONE_MIN_LOG2 out of range for the byte-register base");
   end
   if (ID_W < 1 || ID_W > 4) begin : g_bad_id
      $error("ID_W must be 1..4");
   end

   logic [LMW_CODE_W-1:0]     bios_code;
   zone_cfg_t [NUM_ZONES-1:0] zone_cfg;
   logic                      lock_q;
   logic                      bios_hit;
   logic [NUM_ZONES-1:0]      zone_raw;
   logic [NUM_ZONES-1:0]      zone_sel;
   logic                      taken;

   lpc_memwin_regs #(
      .NUM_ZONES (NUM_ZONES),
      .SEL_W     (SEL_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .sel       (cfg_sel),
      .wdata     (cfg_wdata),
      .rd_data   (cfg_rdata),
      .bios_code (bios_code),
      .zone_cfg  (zone_cfg),
      .lock      (lock_q)
   );

   lpc_memwin_bios #(
      .MIN_LOG2 (BIOS_MIN_LOG2),
      .FWD_W    (FWD_W),
      .ID_W     (ID_W),
      .CHECK_ID (FWH_CHECK_ID),
      .DEV_ID   (DEV_ID)
   ) u_bios (
      .addr   (req_addr),
      .is_fwh (req_fwh),
      .id     (req_id),
      .code   (bios_code),
      .lpc_en (lpc_bios_en),
      .fwh_en (fwh_bios_en),
      .hit    (bios_hit)
   );

   for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
      lpc_memwin_zone #(
         .MIN_LOG2 (ZONE_MIN_LOG2)
      ) u_zone (
         .addr (req_addr),
         .cfg  (zone_cfg[z]),
         .hit  (zone_raw[z])
      );
   end

   // Firmware window first, then zones in index order; zones decode LPC cycles only.
   always_comb begin
      zone_sel = '0;
      taken    = bios_hit;
      for (int z = 0; z < NUM_ZONES; z++) begin
         if (!taken && !req_fwh && zone_raw[z]) begin
            zone_sel[z] = 1'b1;
            taken       = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_bios_hit <= 1'b0;
         out_zone_hit <= '0;
         out_addr     <= '0;
      end else begin
         out_valid    <= req_valid;
         out_bios_hit <= req_valid && bios_hit;
         out_zone_hit <= req_valid ? zone_sel : '0;
         out_addr     <= req_valid ? req_addr[FWD_W-1:0] : '0;
      end
   end

endmodule

// File: rtl/lpc_memwin_chk.sv
module lpc_memwin_chk #(
   parameter int NUM_ZONES = 2,
   parameter int SEL_W     = 3,
   parameter int FWD_W     = 28,
   parameter int MAP_W     = 43
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_we,
   input logic [SEL_W-1:0]      cfg_sel,
   input logic [7:0]            cfg_wdata,
   input logic                  lpc_bios_en,
   input logic                  fwh_bios_en,
   input logic                  req_valid,
   input logic                  req_fwh,
   input logic [31:0]           req_addr,
   input logic                  out_valid,
   input logic                  out_bios_hit,
   input logic [NUM_ZONES-1:0]  out_zone_hit,
   input logic [FWD_W-1:0]      out_addr,
   input logic                  lock_q,
   input logic [MAP_W-1:0]      map_state
);

   // R1: reset empties the output stage
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> !out_valid && !out_bios_hit && out_zone_hit == '0);

   // R7: valid follows the request by one edge
   a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);

   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid && !out_bios_hit && out_zone_hit == '0 && out_addr == '0);

   a_r7_addr_forward: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_addr == $past(req_addr[FWD_W-1:0]));

   // R6: a single winner at most
   a_r6_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_bios_hit, out_zone_hit}));

   // R4: firmware hit only through an enabled path
   a_r4_gated_bios: assert property (@(posedge clk) disable iff (!rst_n)
      out_bios_hit |-> ($past(req_fwh) ? $past(fwh_bios_en) : $past(lpc_bios_en)));

   // R5: zones never answer firmware-hub cycles
   a_r5_zone_lpc_only: assert property (@(posedge clk) disable iff (!rst_n)
      (out_zone_hit != '0) |-> !$past(req_fwh));

   // R8: lock sets on a one and never drops
   a_r8_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == SEL_W'(1) && cfg_wdata[0]) |=> lock_q);

   a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   // R9: mapping frozen under lock
   a_r9_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(map_state));

endmodule

bind lpc_memwin_dec lpc_memwin_chk #(
   .NUM_ZONES (NUM_ZONES),
   .SEL_W     (SEL_W),
   .FWD_W     (FWD_W),
   .MAP_W     (MAP_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_sel      (cfg_sel),
   .cfg_wdata    (cfg_wdata),
   .lpc_bios_en  (lpc_bios_en),
   .fwh_bios_en  (fwh_bios_en),
   .req_valid    (req_valid),
   .req_fwh      (req_fwh),
   .req_addr     (req_addr),
   .out_valid    (out_valid),
   .out_bios_hit (out_bios_hit),
   .out_zone_hit (out_zone_hit),
   .out_addr     (out_addr),
   .lock_q       (lock_q),
   .map_state    ({bios_code, zone_cfg})
);

// File: tb/lpc_memwin_dec_test.sv
module lpc_memwin_dec_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        lpc_bios_en = 1'b1;
   logic        fwh_bios_en = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_fwh = 1'b0;
   logic [3:0]  req_id = '0;
   logic [31:0] req_addr = '0;
   logic        out_valid;
   logic        out_bios_hit;
   logic [1:0]  out_zone_hit;
   logic [27:0] out_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // Shadow of the mapping, following the requirement rules
   logic [2:0] sh_bios;
   logic       sh_lock;
   logic [7:0] sh_hi [2];
   logic [7:0] sh_lo [2];
   logic       sh_en [2];
   logic [2:0] sh_code [2];

   always #4 clk = ~clk;

   lpc_memwin_dec uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_sel      (cfg_sel),
      .cfg_wdata    (cfg_wdata),
      .cfg_rdata    (cfg_rdata),
      .lpc_bios_en  (lpc_bios_en),
      .fwh_bios_en  (fwh_bios_en),
      .req_valid    (req_valid),
      .req_fwh      (req_fwh),
      .req_id       (req_id),
      .req_addr     (req_addr),
      .out_valid    (out_valid),
      .out_bios_hit (out_bios_hit),
      .out_zone_hit (out_zone_hit),
      .out_addr     (out_addr)
   );

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input int s);
      logic [7:0] v = '0;
      if (s == 0) v = {5'b0, sh_bios};
      else if (s == 1) v = {7'b0, sh_lock};
      else begin
         int z = (s - 2) / 3;
         int f = (s - 2) % 3;
         if (f == 0) v = sh_hi[z];
         else if (f == 1) v = sh_lo[z];
         else v = {sh_en[z], 4'b0, sh_code[z]};
      end
      return v;
   endfunction

   function automatic bit exp_bios(input logic [31:0] a, input bit fwh, input logic [3:0] id);
      logic [63:0] sz = 64'h4_0000 << sh_bios;
      if (fwh) return fwh_bios_en && id == 4'h0 && ({36'b0, a[27:0]} >= (64'h1000_0000 - sz));
      return lpc_bios_en && ({32'b0, a} >= (64'h1_0000_0000 - sz));
   endfunction

   function automatic bit exp_zone_raw(input int z, input logic [31:0] a);
      logic [63:0] sz   = 64'h1_0000 << sh_code[z];
      logic [63:0] base = {32'b0, sh_hi[z], sh_lo[z], 16'h0} & ~(sz - 64'd1);
      return sh_en[z] && ({32'b0, a} >= base) && ({32'b0, a} < base + sz);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      sh_bios = '0; sh_lock = 1'b0;
      for (int z = 0; z < 2; z++) begin
         sh_hi[z] = '0; sh_lo[z] = '0; sh_en[z] = 1'b0; sh_code[z] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cfg_write(input int s, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 3'(s); cfg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      if (s == 1) begin
         if (d[0]) sh_lock = 1'b1;
      end else if (!sh_lock) begin
         if (s == 0) sh_bios = d[2:0];
         else begin
            int z = (s - 2) / 3;
            int f = (s - 2) % 3;
            if (f == 0) sh_hi[z] = d;
            else if (f == 1) sh_lo[z] = d;
            else begin sh_en[z] = d[7]; sh_code[z] = d[2:0]; end
         end
      end
   endtask

   task automatic check_rd(input int s, input string rq);
      @(negedge clk);
      cfg_sel = 3'(s);
      #1;
      chk(cfg_rdata == exp_rd(s), rq, $sformatf("readback idx %0d", s),
          {24'b0, cfg_rdata}, {24'b0, exp_rd(s)});
   endtask

   task automatic lookup(input logic [31:0] a, input bit fwh, input logic [3:0] id,
                         input string rq);
      bit         eb = exp_bios(a, fwh, id);
      logic [1:0] ez = '0;
      if (!eb && !fwh) begin
         if (exp_zone_raw(0, a)) ez = 2'b01;
         else if (exp_zone_raw(1, a)) ez = 2'b10;
      end
      @(negedge clk);
      req_valid = 1'b1; req_fwh = fwh; req_id = id; req_addr = a;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(out_valid == 1'b1, "R7", "out_valid", {31'b0, out_valid}, 32'd1);
      chk(out_addr == a[27:0], "R7", "out_addr", {4'b0, out_addr}, {4'b0, a[27:0]});
      chk(out_bios_hit == eb, rq, $sformatf("bios hit @%h fwh=%0d", a, fwh),
          {31'b0, out_bios_hit}, {31'b0, eb});
      chk(out_zone_hit == ez, rq, $sformatf("zone hit @%h fwh=%0d", a, fwh),
          {30'b0, out_zone_hit}, {30'b0, ez});
   endtask

   task automatic t_reset_state();
      do_reset();
      chk(out_valid == 1'b0, "R1", "out_valid", {31'b0, out_valid}, 32'd0);
      chk(out_bios_hit == 1'b0 && out_zone_hit == '0, "R1", "hits",
          {29'b0, out_bios_hit, out_zone_hit}, 32'd0);
      chk(out_addr == '0, "R1", "out_addr", {4'b0, out_addr}, 32'd0);
      for (int s = 0; s < 8; s++) check_rd(s, "R1");
      lookup(32'h0000_0000, 1'b0, 4'h0, "R1");
   endtask

   task automatic t_readback();
      cfg_write(0, 8'hFF);
      check_rd(0, "R10");
      cfg_write(4, 8'hFF);
      check_rd(4, "R10");
      cfg_write(2, 8'hA5);
      check_rd(2, "R10");
      cfg_write(4, 8'h00);
      cfg_write(2, 8'h00);
      cfg_write(0, 8'h00);
      check_rd(4, "R10");
   endtask

   task automatic t_bios_lpc();
      cfg_write(0, 8'h00);
      lookup(32'hFFFC_0000, 1'b0, 4'h0, "R2");
      lookup(32'hFFFB_FFFF, 1'b0, 4'h0, "R2");
      lookup(32'hFFFF_FFFF, 1'b0, 4'h0, "R2");
      cfg_write(0, 8'h03);
      lookup(32'hFFE0_0000, 1'b0, 4'h0, "R2");
      lookup(32'hFFDF_FFFF, 1'b0, 4'h0, "R2");
      cfg_write(0, 8'h07);
      lookup(32'hFE00_0000, 1'b0, 4'h0, "R2");
      lookup(32'hFDFF_FFFF, 1'b0, 4'h0, "R2");
      lookup(32'h0E00_0000, 1'b0, 4'h0, "R2");
   endtask

   task automatic t_bios_fwh();
      cfg_write(0, 8'h00);
      lookup(32'h0FFC_0000, 1'b1, 4'h0, "R3");
      lookup(32'h0FFB_FFFF, 1'b1, 4'h0, "R3");
      lookup(32'h5FFF_0000, 1'b1, 4'h0, "R3");
      lookup(32'h0FFF_0000, 1'b1, 4'h1, "R3");
      cfg_write(0, 8'h07);
      lookup(32'h0E00_0000, 1'b1, 4'h0, "R3");
      lookup(32'h0DFF_FFFF, 1'b1, 4'h0, "R3");
   endtask

   task automatic t_enable_gate();
      cfg_write(0, 8'h00);
      lpc_bios_en = 1'b0;
      lookup(32'hFFFF_FFF0, 1'b0, 4'h0, "R4");
      lookup(32'h0FFF_FFF0, 1'b1, 4'h0, "R4");
      lpc_bios_en = 1'b1; fwh_bios_en = 1'b0;
      lookup(32'h0FFF_FFF0, 1'b1, 4'h0, "R4");
      lookup(32'hFFFF_FFF0, 1'b0, 4'h0, "R4");
      fwh_bios_en = 1'b1;
   endtask

   task automatic t_zones();
      cfg_write(2, 8'h12); cfg_write(3, 8'h34); cfg_write(4, 8'h82);
      lookup(32'h1234_0000, 1'b0, 4'h0, "R5");
      lookup(32'h1237_FFFF, 1'b0, 4'h0, "R5");
      lookup(32'h1238_0000, 1'b0, 4'h0, "R5");
      lookup(32'h1233_FFFF, 1'b0, 4'h0, "R5");
      lookup(32'h1234_0000, 1'b1, 4'h0, "R5");
      // misaligned base falls back to 2000_0000 for a 512 KB block
      cfg_write(5, 8'h20); cfg_write(6, 8'h05); cfg_write(7, 8'h83);
      lookup(32'h2000_0000, 1'b0, 4'h0, "R5");
      lookup(32'h2007_FFFF, 1'b0, 4'h0, "R5");
      lookup(32'h2008_0000, 1'b0, 4'h0, "R5");
      cfg_write(4, 8'h02);
      lookup(32'h1234_0000, 1'b0, 4'h0, "R5");
   endtask

   task automatic t_priority();
      cfg_write(0, 8'h00);
      cfg_write(2, 8'hFF); cfg_write(3, 8'h80); cfg_write(4, 8'h87);
      cfg_write(5, 8'hFF); cfg_write(6, 8'hC0); cfg_write(7, 8'h84);
      lookup(32'hFFFF_0000, 1'b0, 4'h0, "R6");
      lookup(32'hFFC0_1000, 1'b0, 4'h0, "R6");
      lookup(32'hFFF0_0000, 1'b0, 4'h0, "R6");
      cfg_write(4, 8'h07);
      lookup(32'hFFC0_1000, 1'b0, 4'h0, "R6");
   endtask

   task automatic t_idle();
      @(negedge clk);
      chk(!out_valid && !out_bios_hit && out_zone_hit == '0 && out_addr == '0,
          "R7", "idle outputs", {3'b0, out_valid, out_bios_hit, out_zone_hit, 25'b0} | {4'b0, out_addr}, 32'd0);
      lookup(32'hABCD_1234, 1'b0, 4'h0, "R7");
      lookup(32'h7654_3210, 1'b1, 4'h3, "R7");
   endtask

   task automatic t_lock();
      cfg_write(0, 8'h02);
      cfg_write(1, 8'h00);
      check_rd(1, "R8");
      cfg_write(1, 8'h01);
      check_rd(1, "R8");
      cfg_write(1, 8'h00);
      check_rd(1, "R8");
      cfg_write(0, 8'h07);
      check_rd(0, "R9");
      cfg_write(2, 8'h00);
      check_rd(2, "R9");
      cfg_write(4, 8'h00);
      check_rd(4, "R9");
      lookup(32'hFFE0_0000, 1'b0, 4'h0, "R9");
      lookup(32'hFF80_0000, 1'b0, 4'h0, "R9");
      do_reset();
      check_rd(1, "R8");
      cfg_write(0, 8'h05);
      check_rd(0, "R8");
   endtask

   initial begin
      t_reset_state();
      t_readback();
      t_bios_lpc();
      t_bios_fwh();
      t_enable_gate();
      t_zones();
      t_priority();
      t_idle();
      t_lock();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule